// File: doc/BRIEF.md
# Triggered Circular Capture Engine

This block records a 64-bit sample stream into an internal circular RAM and stops a programmed time after a trigger. Once started, it writes one sample word at a decimated rate. The write pointer runs round the buffer until a trigger arrives. The trigger starts a post-trigger timer, and writing stops when that timer expires. The word ahead of the most recent one is then the oldest surviving sample, so a separate readout block can rebuild the record in time order from the wrap flag and the finish index.

Three trigger sources exist:
- one selected bit of a 32-bit debug bus, on a chosen edge;
- a masked equality compare of a second 32-bit debug word against a reference;
- a software trigger written through the register port.

The post-trigger time is a 7-bit count of units, and each unit is a power of two microseconds. A parameterised divider derives the microsecond tick from the block clock. Software starts a capture, polls the busy flag of the active trigger path, and reads the status word when the flag drops.

Top module: `trig_capture_engine`

## Requirements
- R1: After reset, all four registers read zero: control at address 0, mask at address 1, reference at address 2 and status at address 3.
- R2: A control write with bit 0 set while idle starts a capture. From the next clock, bit 24 of the control read is 1 if control bit 1 was 0 (bit-trigger path), or bit 25 is 1 if control bit 1 was 1 (compare path). At most one of these busy bits is ever set. A control write with bit 0 clear returns the block to idle and clears both busy bits from the next clock.
- R3: On the bit-trigger path, control bits 9:5 choose the debug-bus bit. Control bit 4 chooses the edge: 0 is a rising edge, 1 is a falling edge. Activity on any other bit, or the opposite edge on the chosen bit, does not trigger.
- R4: On the compare path, the trigger fires on any armed clock where (compare word AND mask) equals the reference.
- R5: With control bit 2 set, only the software trigger is used. A control write that sets bit 3 while the stored bit 3 is 0 triggers on that write's clock edge. Bus edges and compare matches are ignored while control bit 2 is set.
- R6: Control bits 12:10 give a rate code c. For codes 0 to 6, a sample is written every 2^(c+1) clocks; for code 7, a sample is written every clock. The first write falls one period after the start edge.
- R7: Control bits 19:13 give the unit count N and bits 22:20 give the exponent u; codes above 6 act as 6. Busy falls D+1 clocks after the trigger edge, where D = N * 2^u * CLK_PER_US. When N is 0, busy falls one clock after the trigger.
- R8: A trigger condition that arrives during the post-trigger phase neither restarts nor extends the timer.
- R9: Status bit 31 is set once a write lands in the last buffer slot (DEPTH-1) and stays set until the next start. Status bits 30:16 hold the index of the most recent write. A start clears both fields, and they do not change while the block is idle.
- R10: rd_data shows the stored word at rd_addr one clock after the address is applied. The stored word holds all 64 bits of the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 mask, 2 reference, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| dbg_bus | input | 32 | Debug bus for the bit trigger |
| cmp_word | input | 32 | Debug word for the masked compare trigger |
| sample_in | input | 64 | Sample stream written to the buffer |
| rd_addr | input | ADDR_W | Readout address |
| rd_data | output | 64 | Readout data, one clock after rd_addr |

## Verification
Two functions can act on the same clock edge: the trigger and a decimated sample write. A repeated trigger condition can also coincide with the running post-trigger count. The bench draws the arming delay, rate code, unit exponent and count at random. Trigger edges therefore land before, on and after write edges, and some runs add a second trigger edge partway through the post-trigger phase. Each run is judged by the exact clock on which busy falls and by the status word, compared with a write count computed from the start-to-trigger distance, the post-trigger length and the sample period. The spacing of every stored word is also checked.

// File: rtl/tce_pkg.sv
package tce_pkg;

    localparam int SEL_W  = 5;
    localparam int RATE_W = 3;
    localparam int CNT_W  = 7;
    localparam int EXP_W  = 3;
    localparam int DEC_W  = 8;
    localparam int UNIT_W = 7;

    localparam int CB_EN  = 0;
    localparam int CB_CMP = 1;
    localparam int CB_MAN = 3;
    localparam int BUSY_BIT_POS = 24;
    localparam int BUSY_CMP_POS = 25;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_REF  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic [EXP_W-1:0]  unit_exp;
        logic [CNT_W-1:0]  post_cnt;
        logic [RATE_W-1:0] rate;
        logic [SEL_W-1:0]  bit_sel;
        logic              fall_edge;
        logic              man_trig;
        logic              src_manual;
        logic              cmp_mode;
        logic              enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [DEC_W-1:0] dec_last(input logic [RATE_W-1:0] code);
        if (code == 3'd7) return '0;
        return (DEC_W'(2) << code) - DEC_W'(1);
    endfunction

    function automatic logic [UNIT_W-1:0] unit_last(input logic [EXP_W-1:0] e);
        if (e >= 3'd6) return UNIT_W'(63);
        return (UNIT_W'(1) << e) - UNIT_W'(1);
    endfunction

endpackage

// File: rtl/tce_trigger.sv
module tce_trigger
    import tce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             fall_edge,
    input  logic             cmp_mode,
    input  logic             src_manual,
    input  logic             man_rise,
    input  logic [31:0]      dbg_bus,
    input  logic [31:0]      cmp_word,
    input  logic [31:0]      mask,
    input  logic [31:0]      ref_val,
    output logic             fire
);
    logic cur_bit;
    logic prev_bit_q;
    logic edge_hit;
    logic cmp_hit;
    logic hw_hit;

    assign cur_bit = dbg_bus[bit_sel];

    always_ff @(posedge clk) begin
        if (rst) prev_bit_q <= 1'b0;
        else     prev_bit_q <= cur_bit;
    end

    assign edge_hit = fall_edge ? (prev_bit_q & ~cur_bit) : (cur_bit & ~prev_bit_q);
    assign cmp_hit  = ((cmp_word & mask) == ref_val);
    assign hw_hit   = cmp_mode ? cmp_hit : edge_hit;
    assign fire     = armed & (src_manual ? man_rise : hw_hit);
endmodule

// File: rtl/tce_timebase.sv
module tce_timebase
    import tce_pkg::*;
#(
    parameter int CLK_PER_US = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic              load,
    input  logic              in_post,
    input  logic [RATE_W-1:0] rate,
    input  logic [CNT_W-1:0]  post_cnt,
    input  logic [EXP_W-1:0]  unit_exp,
    output logic              dec_hit,
    output logic              post_zero
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(CLK_PER_US - 1);

    logic [DEC_W-1:0]  dcnt_q;
    logic [PW-1:0]     presc_q;
    logic [UNIT_W-1:0] ucnt_q;
    logic [UNIT_W-1:0] ulast_q;
    logic [CNT_W-1:0]  rem_q;
    logic              us_tick;

    assign dec_hit = run && (dcnt_q == dec_last(rate));

    always_ff @(posedge clk) begin
        if (rst || restart)  dcnt_q <= '0;
        else if (run)        dcnt_q <= dec_hit ? '0 : dcnt_q + DEC_W'(1);
    end

    assign us_tick = (presc_q == PRESC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            ucnt_q  <= '0;
            ulast_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            presc_q <= '0;
            ucnt_q  <= '0;
            ulast_q <= unit_last(unit_exp);
            rem_q   <= post_cnt;
        end else if (in_post && rem_q != '0) begin
            if (us_tick) begin
                presc_q <= '0;
                if (ucnt_q == ulast_q) begin
                    ucnt_q <= '0;
                    rem_q  <= rem_q - CNT_W'(1);
                end else begin
                    ucnt_q <= ucnt_q + UNIT_W'(1);
                end
            end else begin
                presc_q <= presc_q + PW'(1);
            end
        end
    end

    assign post_zero = (rem_q == '0);
endmodule

// File: rtl/tce_buffer.sv
module tce_buffer #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [63:0]       wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic              wrap,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_SLOT = ADDR_W'(DEPTH - 1);

    logic [63:0]       mem [DEPTH];
    logic [ADDR_W-1:0] wptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr_q] <= wdata;
        rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr_q    <= '0;
            wrap      <= 1'b0;
            last_addr <= '0;
        end else if (wr_en) begin
            last_addr <= wptr_q;
            wptr_q    <= wptr_q + ADDR_W'(1);
            if (wptr_q == TOP_SLOT) wrap <= 1'b1;
        end
    end
endmodule

// File: rtl/trig_capture_engine.sv
module trig_capture_engine
    import tce_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       dbg_bus,
    input  logic [31:0]       cmp_word,
    input  logic [63:0]       sample_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data
);
    localparam int STAT_PTR_W = 15;

    cap_state_e        state_q, state_d;
    ctrl_t             ctrl_q;
    logic [31:0]       mask_q;
    logic [31:0]       ref_q;
    logic              cap_cmp_q;
    logic              ctrl_wr;
    logic              start_req;
    logic              abort_req;
    logic              man_rise;
    logic              armed;
    logic              active;
    logic              fire;
    logic              dec_hit;
    logic              post_zero;
    logic              wr_en;
    logic              buf_wrap;
    logic [ADDR_W-1:0] buf_last;
    logic              bb_busy;
    logic              mac_busy;
    logic [31:0]       stat_word;

    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign start_req = ctrl_wr && reg_wdata[CB_EN] && (state_q == ST_IDLE);
    assign abort_req = ctrl_wr && !reg_wdata[CB_EN];
    assign man_rise  = ctrl_wr && reg_wdata[CB_MAN] && !ctrl_q.man_trig;
    assign armed     = (state_q == ST_ARMED) && !abort_req;
    assign active    = (state_q != ST_IDLE);
    assign wr_en     = active && dec_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctrl_q    <= '0;
            mask_q    <= '0;
            ref_q     <= '0;
            cap_cmp_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
            if (reg_wr && reg_addr == A_REF)  ref_q  <= reg_wdata;
            if (start_req) cap_cmp_q <= reg_wdata[CB_CMP];
        end
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_req) state_d = ST_ARMED;
            ST_ARMED: begin
                if (abort_req)  state_d = ST_IDLE;
                else if (fire)  state_d = ST_POST;
            end
            ST_POST: begin
                if (abort_req || post_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    tce_trigger trig_i (
        .clk        (clk),
        .rst        (rst),
        .armed      (armed),
        .bit_sel    (ctrl_q.bit_sel),
        .fall_edge  (ctrl_q.fall_edge),
        .cmp_mode   (ctrl_q.cmp_mode),
        .src_manual (ctrl_q.src_manual),
        .man_rise   (man_rise),
        .dbg_bus    (dbg_bus),
        .cmp_word   (cmp_word),
        .mask       (mask_q),
        .ref_val    (ref_q),
        .fire       (fire)
    );

    tce_timebase #(.CLK_PER_US(CLK_PER_US)) tb_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (start_req),
        .run       (active),
        .load      (fire),
        .in_post   (state_q == ST_POST),
        .rate      (ctrl_q.rate),
        .post_cnt  (ctrl_q.post_cnt),
        .unit_exp  (ctrl_q.unit_exp),
        .dec_hit   (dec_hit),
        .post_zero (post_zero)
    );

    tce_buffer #(.ADDR_W(ADDR_W)) buf_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_req),
        .wr_en     (wr_en),
        .wdata     (sample_in),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wrap      (buf_wrap),
        .last_addr (buf_last)
    );

    assign bb_busy   = active && !cap_cmp_q;
    assign mac_busy  = active && cap_cmp_q;
    assign stat_word = {buf_wrap, STAT_PTR_W'(buf_last), 16'd0};

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {6'd0, mac_busy, bb_busy, 1'b0, ctrl_q};
            A_MASK:  reg_rdata = mask_q;
            A_REF:   reg_rdata = ref_q;
            default: reg_rdata = stat_word;
        endcase
    end
endmodule

// File: rtl/tce_checker.sv
module tce_checker
    import tce_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input cap_state_e        state_q,
    input logic              start_req,
    input logic              abort_req,
    input logic              post_zero,
    input logic              bb_busy,
    input logic              mac_busy,
    input logic              buf_wrap,
    input logic [ADDR_W-1:0] buf_last
);
    p_busy_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bb_busy, mac_busy}));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_req |=> (bb_busy || mac_busy));

    p_abort_idle_r2: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (!bb_busy && !mac_busy));

    p_zero_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST && post_zero && !abort_req) |=> (state_q == ST_IDLE));

    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_req) |=> ($stable(buf_wrap) && $stable(buf_last)));

    p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (buf_wrap && !start_req) |=> buf_wrap);
endmodule

bind trig_capture_engine tce_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .start_req (start_req),
    .abort_req (abort_req),
    .post_zero (post_zero),
    .bb_busy   (bb_busy),
    .mac_busy  (mac_busy),
    .buf_wrap  (buf_wrap),
    .buf_last  (buf_last)
);

// File: tb/trig_capture_engine_tb_top.sv
module trig_capture_engine_tb_top;
    localparam int CPU   = 4;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] TAG = 32'h5A5A_C3C3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [31:0]   dbg_bus = '0;
    logic [31:0]   cmp_word = '0;
    logic [31:0]   cyc = '0;
    logic [63:0]   sample_in;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 32'd1;
    assign sample_in = {TAG, cyc};

    trig_capture_engine #(.CLK_PER_US(CPU), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_bus(dbg_bus),
        .cmp_word(cmp_word), .sample_in(sample_in), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] mk_ctrl(input int en, input int cmp, input int src,
                                            input int man, input int fall, input int sel,
                                            input int rate, input int n, input int u);
        return {9'd0, 3'(u), 7'(n), 3'(rate), 5'(sel), 1'(fall), 1'(man), 1'(src),
                1'(cmp), 1'(en)};
    endfunction

    function automatic int period_of(input int rate);
        return (rate == 7) ? 1 : (2 << rate);
    endfunction

    function automatic int post_len(input int n, input int u);
        int ue = (u > 6) ? 6 : u;
        return n * CPU * (1 << ue);
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic busy_bits(output logic [1:0] b);
        logic [31:0] v;
        reg_read(2'd0, v);
        b = v[25:24];
    endtask

    task automatic rd_word(input int a, output logic [63:0] d);
        rd_addr = AW'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    // R6 spacing, R9 status, R10 readout after a capture of known geometry
    task automatic check_result(input string what, input int j, input int d, input int rate);
        int p = period_of(rate);
        int writes = (j + d + 1) / p;
        logic [31:0] st;
        logic [63:0] a_v, b_v;
        int last;
        bit wr;
        int pairs;
        logic [31:0] gap;
        int exp_last = (writes == 0) ? 0 : ((writes - 1) % DEPTH);
        reg_read(2'd3, st);
        check({"R9 wrap flag ", what}, st[31], (writes >= DEPTH) ? 1 : 0);
        check({"R9 finish index ", what}, st[30:16], exp_last);
        check({"R9 low status bits ", what}, st[15:0], 0);
        last = int'(st[30:16]);
        wr   = st[31];
        if (writes > 0) begin
            rd_word(last, a_v);
            check({"R10 upper half ", what}, a_v[63:32], TAG);
            pairs = wr ? DEPTH - 1 : last;
            gap = 32'(p);
            for (int i = 0; i < pairs; i++) begin
                rd_word((last - i) & (DEPTH - 1), a_v);
                rd_word((last - i - 1) & (DEPTH - 1), b_v);
                if (a_v[31:0] - b_v[31:0] != 32'(p) && gap == 32'(p))
                    gap = a_v[31:0] - b_v[31:0];
            end
            check({"R6 sample spacing ", what}, gap, p);
        end
    endtask

    // waits after the trigger edge: busy at Pt+D, idle at Pt+D+1 (R7)
    task automatic check_end(input string what, input int d, input int pre);
        logic [1:0] b;
        repeat (d + 1 - pre) @(negedge clk);
        busy_bits(b);
        check({"R7 busy held to end ", what}, (b != 2'b00), 1);
        @(negedge clk);
        busy_bits(b);
        check({"R7 R8 idle after post time ", what}, b, 2'b00);
    endtask

    task automatic bit_capture(input int fall, input int sel, input int rate, input int n,
                               input int u, input int k, input int retrig);
        int other = (sel + 1 + int'($urandom % 31)) % 32;
        int d = post_len(n, u);
        int pre = 0;
        logic [1:0] b;
        logic [31:0] sb = 32'd1 << sel;
        dbg_bus = fall ? sb : 32'd0;
        reg_write(2'd0, mk_ctrl(1, 0, 0, 0, fall, sel, rate, n, u));
        busy_bits(b);
        check("R2 bit path busy set", b, 2'b01);
        dbg_bus = dbg_bus | (32'd1 << other);
        repeat (k) @(negedge clk);
        busy_bits(b);
        check("R3 other bit ignored", b, 2'b01);
        dbg_bus = fall ? (dbg_bus & ~sb) : (dbg_bus | sb);
        if (retrig != 0 && d >= 1) begin
            @(negedge clk); dbg_bus = dbg_bus ^ sb;
            @(negedge clk); dbg_bus = dbg_bus ^ sb;
            pre = 2;
        end
        check_end("bit trigger", d, pre);
        check_result("bit trigger", k + 1, d, rate);
    endtask

    initial begin
        logic [31:0] v;
        logic [1:0]  b;
        int sd;
        sd = int'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check("R1 reset register value", v, 0);
        end

        // R2 start then abort; later edges have no effect
        dbg_bus = '0;
        reg_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 3, 2, 2, 0));
        busy_bits(b);
        check("R2 busy after start", b, 2'b01);
        reg_write(2'd0, mk_ctrl(0, 0, 0, 0, 0, 3, 2, 2, 0));
        busy_bits(b);
        check("R2 busy cleared by abort", b, 2'b00);
        dbg_bus = 32'd1 << 3;
        repeat (4) @(negedge clk);
        busy_bits(b);
        check("R2 idle ignores trigger", b, 2'b00);
        dbg_bus = '0;

        // directed corners
        bit_capture(0, 7, 6, 1, 0, 3, 0);   // R6 slow rate, no write at all
        bit_capture(1, 0, 0, 0, 0, 9, 0);   // R7 count zero, falling edge R3
        bit_capture(0, 31, 7, 2, 1, 90, 1); // R9 wrap with full rate, R8 retrigger
        bit_capture(0, 12, 1, 1, 6, 5, 1);  // R7 largest unit exponent
        bit_capture(1, 20, 3, 2, 7, 4, 0);  // R7 exponent code 7 acts as 6

        // random bit-trigger captures
        for (int it = 0; it < 12; it++) begin
            bit_capture(int'($urandom % 2), int'($urandom % 32), int'($urandom % 8),
                        1 + int'($urandom % 4), int'($urandom % 3),
                        1 + int'($urandom % 80), int'($urandom % 2));
        end

        // R4 compare path
        for (int it = 0; it < 4; it++) begin
            logic [31:0] m, r;
            int rate = int'($urandom % 8);
            int n = 1 + int'($urandom % 3);
            int u = int'($urandom % 2);
            int k = 1 + int'($urandom % 40);
            m = $urandom | 32'd1;
            r = $urandom & m;
            reg_write(2'd1, m);
            reg_write(2'd2, r);
            cmp_word = ~r & m;
            reg_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, rate, n, u));
            busy_bits(b);
            check("R2 R4 compare path busy", b, 2'b10);
            repeat (k) @(negedge clk);
            busy_bits(b);
            check("R4 mismatch does not trigger", b, 2'b10);
            cmp_word = r | ($urandom & ~m);
            check_end("compare trigger R4", post_len(n, u), 0);
            check_result("compare trigger R4", k + 1, post_len(n, u), rate);
            cmp_word = ~r & m;
        end

        // R5 software trigger
        for (int it = 0; it < 3; it++) begin
            int rate = int'($urandom % 8);
            int n = 1 + int'($urandom % 3);
            int u = int'($urandom % 2);
            int k = 1 + int'($urandom % 30);
            int sel = int'($urandom % 32);
            dbg_bus = '0;
            reg_write(2'd0, mk_ctrl(1, 0, 1, 0, 0, sel, rate, n, u));
            repeat (k) @(negedge clk);
            dbg_bus = 32'd1 << sel;
            repeat (3) @(negedge clk);
            busy_bits(b);
            check("R5 bus edge ignored under software source", b, 2'b01);
            reg_write(2'd0, mk_ctrl(1, 0, 1, 1, 0, sel, rate, n, u));
            check_end("software trigger R5", post_len(n, u), 1);
            check_result("software trigger R5", k + 5, post_len(n, u), rate);
            dbg_bus = '0;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule